// File: doc/BRIEF.md
# Redundant-Thread Load Forwarding Queue

This block carries load results from a leading thread to a redundant trailing thread that runs the same program. Each load the leading thread performs is pushed with its address and returned data. When the trailing thread later executes the same load, it takes the data from this queue and does not go to the cache. The address the trailing load presents is compared with the address the leading load recorded, so a fault that bent the trailing address is caught as soon as the load reads.

The leading thread may load down a path that later turns out to be mispredicted. For that reason each branch can save the current write position under a small tag. A misprediction on that branch puts the write position back, which drops every entry written after the save. Each stored entry carries parity bits for its address and its data. A trailing read whose entry fails that check is reported and does not take the entry.

Top module: `dup_load_queue`

## Requirements
- R1: While the queue holds fewer than DEPTH entries, `ld_ready_o` is high, and a `ld_valid_i` cycle appends the address and data as the youngest entry. Entries leave in the order they were written.
- R2: A trailing request (`tr_req_i`) to a non-empty queue whose address equals the oldest entry's address raises `tr_ok_o` in the same cycle. `tr_data_o` then shows that entry's data, and the entry is removed at the clock edge. At most one of `tr_ok_o`, `tr_wait_o`, `tr_fault_o` and `tr_corrupt_o` is high in any cycle.
- R3: With DEPTH entries held, `q_full_o` is high and `ld_ready_o` is low. A push offered while the queue is full is dropped and leaves the contents unchanged.
- R4: A trailing request to an empty queue raises `tr_wait_o`, and no entry is removed.
- R5: A trailing request whose address differs from the oldest entry's address raises `tr_fault_o`. The entry stays, so a later request with the correct address still receives it.
- R6: `br_save_i` records the current write position under `br_save_tag_i`. `br_undo_i` with a saved tag restores that position, so the entries written after the save are discarded.
- R7: A save and a push in the same cycle record the position before that push. Undoing that tag therefore drops the entry pushed in that cycle.
- R8: An undo that takes effect has priority over everything else in its cycle. A push in that cycle is dropped, and a save in that cycle is not recorded.
- R9: An undo naming a tag that has not been saved since reset is ignored, and a push in the same cycle is accepted.
- R10: Every entry holds one parity bit over its address and one over its data. `tr_corrupt_o` reports a read whose stored bits do not match, and it never rises for entries written through the push port.
- R11: After reset the queue is empty and not full, no checkpoint is saved, and no trailing verdict is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Leading load offers an entry |
| ld_addr_i | input | ADDR_W | Leading load address |
| ld_data_i | input | DATA_W | Leading load data |
| ld_ready_o | output | 1 | Queue can accept an entry |
| tr_req_i | input | 1 | Trailing load asks for its value |
| tr_addr_i | input | ADDR_W | Trailing load address |
| tr_data_o | output | DATA_W | Data of the oldest entry |
| tr_ok_o | output | 1 | Address matched, entry delivered |
| tr_wait_o | output | 1 | Queue empty, retry later |
| tr_fault_o | output | 1 | Trailing address differs from recorded one |
| tr_corrupt_o | output | 1 | Stored parity check failed |
| br_save_i | input | 1 | Branch saves the write position |
| br_save_tag_i | input | TAG_W | Checkpoint slot to write |
| br_undo_i | input | 1 | Misprediction restores the write position |
| br_undo_tag_i | input | TAG_W | Checkpoint slot to restore from |
| q_full_o | output | 1 | DEPTH entries held |
| q_empty_o | output | 1 | No entries held |

## Verification
The assertions take for granted that an undo only names a checkpoint whose saved position is not older than the oldest unread entry. In other words, the trailing thread never reads past a branch that the leading thread later undoes. Without that, the restored occupancy would wrap. The stimulus respects this rule by running every save and undo before the reads that would pass the saved position. A reference model in the bench computes, from the requirements, whether each push, save and undo is taken. That model is what decides every expected verdict and data value.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

  typedef enum logic [2:0] {
    RSP_IDLE,
    RSP_WAIT,
    RSP_HIT,
    RSP_ADDR_BAD,
    RSP_PAR_BAD
  } rsp_e;

  // distance between two ring positions that carry one extra wrap bit
  function automatic logic [31:0] ring_occ(input logic [31:0] wr_pos,
                                           input logic [31:0] rd_pos,
                                           input int unsigned cw);
    logic [31:0] mask;
    mask = (32'd1 << cw) - 32'd1;
    return (wr_pos - rd_pos) & mask;
  endfunction

endpackage

// File: rtl/dlq_store.sv
module dlq_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     widx,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_data,
  input  logic [PW-1:0]     ridx,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_data,
  output logic              r_par_ok
);

  function automatic logic fold_a(input logic [ADDR_W-1:0] v);
    return ^v;
  endfunction

  function automatic logic fold_d(input logic [DATA_W-1:0] v);
    return ^v;
  endfunction

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [1:0]        prot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = we && (widx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        prot_q[g] <= 2'b00;
      end else if (hit) begin
        addr_q[g] <= w_addr;
        data_q[g] <= w_data;
        prot_q[g] <= {fold_a(w_addr), fold_d(w_data)};
      end
    end
  end

  logic [1:0] rd_prot;
  always_comb begin
    r_addr   = addr_q[ridx];
    r_data   = data_q[ridx];
    rd_prot  = prot_q[ridx];
    r_par_ok = (fold_a(r_addr) == rd_prot[1]) && (fold_d(r_data) == rd_prot[0]);
  end

endmodule

// File: rtl/dlq_ckpt.sv
module dlq_ckpt #(
  parameter int CKPT_N = 4,
  parameter int CW     = 4,
  localparam int TW    = (CKPT_N > 1) ? $clog2(CKPT_N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save,
  input  logic [TW-1:0] save_tag,
  input  logic [CW-1:0] save_pos,
  input  logic [TW-1:0] look_tag,
  output logic [CW-1:0] look_pos,
  output logic          look_valid
);

  logic [CW-1:0] pos_q [CKPT_N];
  logic          vld_q [CKPT_N];

  for (genvar g = 0; g < CKPT_N; g++) begin : g_ck
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (save && (save_tag == TW'(g))) begin
        pos_q[g] <= save_pos;
        vld_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    look_pos   = '0;
    look_valid = 1'b0;
    if (int'(look_tag) < CKPT_N) begin
      look_pos   = pos_q[look_tag];
      look_valid = vld_q[look_tag];
    end
  end

endmodule

// File: rtl/dlq_judge.sv
module dlq_judge
  import dlq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              req,
  input  logic              empty,
  input  logic              par_ok,
  input  logic [ADDR_W-1:0] want_addr,
  input  logic [ADDR_W-1:0] held_addr,
  output rsp_e              verdict
);

  always_comb begin
    if (!req)                        verdict = RSP_IDLE;
    else if (empty)                  verdict = RSP_WAIT;
    else if (!par_ok)                verdict = RSP_PAR_BAD;
    else if (want_addr != held_addr) verdict = RSP_ADDR_BAD;
    else                             verdict = RSP_HIT;
  end

endmodule

// File: rtl/dup_load_queue.sv
module dup_load_queue
  import dlq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CKPT_N = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1,
  localparam int TAG_W = (CKPT_N > 1) ? $clog2(CKPT_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              ld_ready_o,
  input  logic              tr_req_i,
  input  logic [ADDR_W-1:0] tr_addr_i,
  output logic [DATA_W-1:0] tr_data_o,
  output logic              tr_ok_o,
  output logic              tr_wait_o,
  output logic              tr_fault_o,
  output logic              tr_corrupt_o,
  input  logic              br_save_i,
  input  logic [TAG_W-1:0]  br_save_tag_i,
  input  logic              br_undo_i,
  input  logic [TAG_W-1:0]  br_undo_tag_i,
  output logic              q_full_o,
  output logic              q_empty_o
);

  logic [CW-1:0] head_q, tail_q;
  logic [CW-1:0] occ;
  logic          full, empty;

  // named events for the checker
  logic          push_take, pop_take, save_take, undo_take;
  logic [CW-1:0] ck_pos;
  logic          ck_valid;

  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data;
  logic              held_par_ok;
  rsp_e              verdict;

  assign occ   = CW'(ring_occ(32'(tail_q), 32'(head_q), CW));
  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);

  assign undo_take = br_undo_i && ck_valid;
  assign push_take = ld_valid_i && !full && !undo_take;
  assign save_take = br_save_i && !undo_take;
  assign pop_take  = (verdict == RSP_HIT);

  dlq_store #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .we      (push_take),
    .widx    (tail_q[PW-1:0]),
    .w_addr  (ld_addr_i),
    .w_data  (ld_data_i),
    .ridx    (head_q[PW-1:0]),
    .r_addr  (held_addr),
    .r_data  (held_data),
    .r_par_ok(held_par_ok)
  );

  dlq_ckpt #(
    .CKPT_N(CKPT_N),
    .CW    (CW)
  ) u_ckpt (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .save      (save_take),
    .save_tag  (br_save_tag_i),
    .save_pos  (tail_q),
    .look_tag  (br_undo_tag_i),
    .look_pos  (ck_pos),
    .look_valid(ck_valid)
  );

  dlq_judge #(
    .ADDR_W(ADDR_W)
  ) u_judge (
    .req      (tr_req_i),
    .empty    (empty),
    .par_ok   (held_par_ok),
    .want_addr(tr_addr_i),
    .held_addr(held_addr),
    .verdict  (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop_take)       head_q <= head_q + CW'(1);
      if (undo_take)      tail_q <= ck_pos;
      else if (push_take) tail_q <= tail_q + CW'(1);
    end
  end

  assign ld_ready_o   = !full;
  assign q_full_o     = full;
  assign q_empty_o    = empty;
  assign tr_data_o    = held_data;
  assign tr_ok_o      = (verdict == RSP_HIT);
  assign tr_wait_o    = (verdict == RSP_WAIT);
  assign tr_fault_o   = (verdict == RSP_ADDR_BAD);
  assign tr_corrupt_o = (verdict == RSP_PAR_BAD);

endmodule

// File: rtl/dlq_checker.sv
module dlq_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] head,
  input logic [CW-1:0] tail,
  input logic [CW-1:0] ck_pos,
  input logic          undo_take,
  input logic          full,
  input logic          empty,
  input logic          tr_req,
  input logic          tr_ok,
  input logic          tr_wait,
  input logic          tr_fault,
  input logic          tr_corrupt
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !undo_take |=> tail == $past(tail));

  // R4
  empty_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req && empty |-> tr_wait && !tr_ok);

  // R5
  fault_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fault |=> head == $past(head));

  // R6
  undo_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undo_take |=> tail == $past(ck_pos));

  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tr_ok, tr_wait, tr_fault, tr_corrupt}));

  // R10
  no_corrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_corrupt);

endmodule

bind dup_load_queue dlq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .occ       (occ),
  .head      (head_q),
  .tail      (tail_q),
  .ck_pos    (ck_pos),
  .undo_take (undo_take),
  .full      (full),
  .empty     (empty),
  .tr_req    (tr_req_i),
  .tr_ok     (tr_ok_o),
  .tr_wait   (tr_wait_o),
  .tr_fault  (tr_fault_o),
  .tr_corrupt(tr_corrupt_o)
);

// File: tb/dup_load_queue_bench.sv
module dup_load_queue_bench;

  localparam int DEPTH = 8, AW = 16, DW = 32, CKN = 4, TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic          tr_req = 1'b0;
  logic [AW-1:0] tr_addr = '0;
  logic          sv = 1'b0, un = 1'b0;
  logic [TW-1:0] sv_tag = '0, un_tag = '0;
  logic          ld_ready, tr_ok, tr_wait, tr_fault, tr_corrupt, full, empty;
  logic [DW-1:0] tr_data;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model: absolute positions
  logic [AW-1:0] m_addr [256];
  logic [DW-1:0] m_data [256];
  int m_head = 0, m_tail = 0;
  int ck_pos [CKN];
  bit ck_ok  [CKN];

  always #4 clk = ~clk;

  dup_load_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .CKPT_N(CKN)) u_dup_load_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_data_i(ld_data), .ld_ready_o(ld_ready),
    .tr_req_i(tr_req), .tr_addr_i(tr_addr), .tr_data_o(tr_data),
    .tr_ok_o(tr_ok), .tr_wait_o(tr_wait), .tr_fault_o(tr_fault), .tr_corrupt_o(tr_corrupt),
    .br_save_i(sv), .br_save_tag_i(sv_tag), .br_undo_i(un), .br_undo_tag_i(un_tag),
    .q_full_o(full), .q_empty_o(empty)
  );

  task automatic chk(input bit good, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, check before the rising edge, update model
  task automatic cyc(input string req,
                     input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input bit tq, input logic [AW-1:0] ta,
                     input bit s, input int st, input bit u, input int ut);
    int occ;
    bit e_ok, e_wait, e_fault, undo_ok, push_ok;
    ld_valid = lv; ld_addr = la; ld_data = ld;
    tr_req = tq; tr_addr = ta;
    sv = s; sv_tag = TW'(st); un = u; un_tag = TW'(ut);
    #2;
    occ = m_tail - m_head;
    e_wait  = tq && occ == 0;
    e_fault = tq && occ != 0 && ta != m_addr[m_head % 256];
    e_ok    = tq && occ != 0 && ta == m_addr[m_head % 256];
    chk(ld_ready == (occ < DEPTH), "R1", "ld_ready", 32'(ld_ready), 32'(occ < DEPTH));
    chk(full == (occ == DEPTH), "R3", "full", 32'(full), 32'(occ == DEPTH));
    chk(empty == (occ == 0), "R4", "empty", 32'(empty), 32'(occ == 0));
    chk(tr_wait == e_wait, req, "tr_wait", 32'(tr_wait), 32'(e_wait));
    chk(tr_fault == e_fault, req, "tr_fault", 32'(tr_fault), 32'(e_fault));
    chk(tr_ok == e_ok, req, "tr_ok", 32'(tr_ok), 32'(e_ok));
    chk(!tr_corrupt, "R10", "tr_corrupt", 32'(tr_corrupt), 32'd0);
    if (e_ok)
      chk(tr_data == m_data[m_head % 256], req, "tr_data", tr_data, m_data[m_head % 256]);
    undo_ok = u && ck_ok[ut];
    push_ok = lv && occ < DEPTH && !undo_ok;
    if (s && !undo_ok) begin ck_pos[st] = m_tail; ck_ok[st] = 1'b1; end
    if (push_ok) begin
      m_addr[m_tail % 256] = la; m_data[m_tail % 256] = ld;
    end
    if (e_ok) m_head++;
    if (undo_ok) m_tail = ck_pos[ut];
    else if (push_ok) m_tail++;
    @(negedge clk);
    ld_valid = 0; tr_req = 0; sv = 0; un = 0;
  endtask

  task automatic push(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(req, 1, a, d, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic pull(input string req, input logic [AW-1:0] a);
    cyc(req, 0, '0, '0, 1, a, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < CKN; i++) begin ck_ok[i] = 0; ck_pos[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    #1;
    chk(empty && !full && ld_ready, "R11", "flags", {29'd0, empty, full, ld_ready}, 32'b101);
    chk(!tr_ok && !tr_wait && !tr_fault && !tr_corrupt, "R11", "verdict", 32'(tr_ok), 32'd0);
    @(negedge clk);

    pull("R4", 16'h0010);                      // empty read waits
    push("R1", 16'h0100, 32'hA000_0001);
    push("R1", 16'h0104, 32'hA000_0002);
    push("R1", 16'h0108, 32'hA000_0003);
    pull("R2", 16'h0100);
    pull("R5", 16'h0999);                      // mismatch keeps entry
    pull("R5", 16'h0104);                      // still delivered afterwards
    pull("R2", 16'h0108);
    pull("R4", 16'h0108);

    // fill, overfill, drain
    for (int i = 0; i < DEPTH; i++) push("R1", AW'(16'h2000 + 4 * i), 32'hB000_0000 + i);
    push("R3", 16'h2F00, 32'hDEAD_0001);       // dropped while full
    push("R3", 16'h2F04, 32'hDEAD_0002);
    for (int i = 0; i < DEPTH; i++) pull("R3", AW'(16'h2000 + 4 * i));
    pull("R3", 16'h2F00);                      // dropped entries never appear

    // checkpoints
    push("R6", 16'h3000, 32'hC000_0000);                              // A
    cyc("R7", 1, 16'h3004, 32'hC000_0001, 0, '0, 1, 1, 0, 0);         // save tag1 + B
    push("R6", 16'h3008, 32'hC000_0002);                              // C
    cyc("R8", 1, 16'h30F0, 32'hC000_00FF, 0, '0, 0, 0, 1, 1);         // undo tag1, push dropped
    push("R6", 16'h300C, 32'hC000_0003);                              // D
    cyc("R9", 1, 16'h3010, 32'hC000_0004, 0, '0, 0, 0, 1, 3);         // unsaved tag3: E kept
    cyc("R8", 0, '0, '0, 0, '0, 1, 0, 1, 1);                          // save tag0 ignored
    cyc("R9", 1, 16'h3014, 32'hC000_0005, 0, '0, 0, 0, 1, 0);         // tag0 unsaved: F kept
    pull("R6", 16'h3000);
    pull("R7", 16'h3004);                      // B dropped: mismatch against F
    pull("R9", 16'h3014);
    pull("R6", 16'h3014);                      // now empty

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule